// File: doc/BRIEF.md
# Wide Parallel Frame-Synchronous Scrambler

This block whitens a wide parallel data word on the transmit side of an optical transport framer. Each clock it produces L pseudorandom bits in one step from a 16-bit linear feedback state and XORs them with the incoming word. The L bits come from a look-ahead XOR network, and a constant function builds that network when the design is compiled for whatever width L is chosen. The default is 640 lanes, so one word per cycle at 156.25 MHz carries 100 Gbit/s.

Lane 0 of each word is the bit that goes on the line first. The generator is x^16 + x^12 + x^3 + x + 1, and it runs as the following serial sequence. The bit sent on a lane is state bit 15. The state then moves one place towards bit 15, and bit 0 takes the XOR of state bits 15, 11, 2 and 0. A beat with the seed marker set is the last beat of a frame alignment word. On that beat the generator restarts from the all-ones state at the first lane after the alignment word. A cut input gives the number of lanes in that beat that still belong to the alignment word, and only the lanes after it are scrambled.

A two-state controller tracks whether an alignment has been seen since reset:

- HUNT is the state after reset. Valid words pass through unchanged.
- Transition ALIGN: a valid seed beat moves the controller from HUNT to RUN.
- RUN: the block scrambles continuously.
- Transition RESEED: a valid seed beat in RUN stays in RUN and restarts the sequence.
- Transition ADVANCE: a valid beat without the seed marker in RUN stays in RUN and moves the sequence on by L bits.

Top module: `otn_wide_scrambler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_vld is 0 and out_data is all zeros. The controller then starts in HUNT with the state at all ones.
- R2: In HUNT, a valid beat without the seed marker appears on out_data unchanged one cycle later.
- R3: In RUN, each lane i of a valid beat leaves as in_data[i] XOR the serial sequence bit. The lanes use consecutive sequence bits in lane order (lane 0 first), and the sequence continues across successive valid beats. The serial sequence is: output state bit 15, shift towards bit 15, and load bit 0 with the XOR of bits 15, 11, 2 and 0.
- R4: Each seed restarts the generator from the all-ones state, and the generator state is never all zeros.
- R5: A valid seed beat whose in_cut is 0 or at least L passes through unscrambled. The next valid beat starts at the all-ones state on lane 0.
- R6: A valid seed beat with in_cut = c, where 1 <= c < L, passes lanes 0 to c-1 unscrambled. Lanes c to L-1 are scrambled starting from the all-ones state, and the next valid beat continues that sequence.
- R7: A seed beat in RUN, including seed beats back to back, restarts the sequence exactly as R5 and R6 describe.
- R8: While in_vld is 0, the generator state does not advance and out_data keeps its last value.
- R9: out_vld equals in_vld delayed by one cycle.
- R10: The same behaviour holds for any L from 2 upward, including widths smaller than the state register.
- R11: A seed marker on a beat with in_vld at 0 is ignored, so the following valid beat continues the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word valid |
| in_seed | input | 1 | Marks the last beat of an alignment word |
| in_cut | input | max(1,clog2(L)) | Number of alignment lanes in a seed beat; 0 or a value of L or more means the whole beat |
| in_data | input | L | Input word, lane 0 sent first |
| out_vld | output | 1 | Output word valid |
| out_data | output | L | Scrambled word |

## Verification
The bench goes after the seed beat in every form it can take. The cut is tested at zero, at one, at the last lane, in the middle of the word and outside the legal range. A wrong shift or a wrong restart state would leave every lane after the boundary mismatched against the serial model. Other cases are idle beats placed between scrambled beats and a seed marker raised without valid. A design that advanced the state while idle, or honoured that seed, would run ahead or restart and would then mismatch the serial model. A 2-lane instance runs next to the 640-lane one, and words are fed with all-zero data so the raw sequence is visible. A look-ahead network built for the wrong width, or assuming at least 16 lanes, would fail there.

// File: rtl/wscr_pkg.sv
package wscr_pkg;

    localparam int unsigned SW = 16;

    // Taps at state bits 15, 11, 2 and 0 for x^16 + x^12 + x^3 + x + 1
    localparam logic [SW-1:0] TAP_MASK = 16'h8805;
    localparam logic [SW-1:0] SEED_VAL = '1;

    typedef logic [SW-1:0] lfsr_t;

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } fsm_t;

    typedef enum logic [1:0] {
        SEL_PASS = 2'd0,
        SEL_SEED = 2'd1,
        SEL_RUN  = 2'd2
    } sel_t;

    // One serial step: emit bit 15, shift up, feed bit 0
    function automatic lfsr_t step_state(input lfsr_t s);
        return {s[SW-2:0], ^(s & TAP_MASK)};
    endfunction

endpackage

// File: rtl/wscr_lookahead.sv
module wscr_lookahead
    import wscr_pkg::*;
#(
    parameter int unsigned L = 640
) (
    input  lfsr_t          cur,
    output logic [L-1:0]   prbs,
    output lfsr_t          nxt
);

    localparam int unsigned ROWS = L + SW;

    // Rows 0..L-1: masks for output lanes; rows L..L+SW-1: next-state bits
    function automatic logic [ROWS-1:0][SW-1:0] build_rows();
        logic [SW-1:0][SW-1:0] m;
        logic [SW-1:0]         fb;
        logic [ROWS-1:0][SW-1:0] r;
        r = '0;
        for (int j = 0; j < int'(SW); j++) begin
            m[j] = lfsr_t'(1) << j;
        end
        for (int k = 0; k < int'(L); k++) begin
            r[k] = m[SW-1];
            fb = '0;
            for (int j = 0; j < int'(SW); j++) begin
                if (TAP_MASK[j]) fb = fb ^ m[j];
            end
            for (int j = int'(SW) - 1; j > 0; j--) begin
                m[j] = m[j-1];
            end
            m[0] = fb;
        end
        for (int j = 0; j < int'(SW); j++) begin
            r[int'(L) + j] = m[j];
        end
        return r;
    endfunction

    localparam logic [ROWS-1:0][SW-1:0] MAT = build_rows();

    generate
        for (genvar g = 0; g < int'(L); g++) begin : g_lane
            assign prbs[g] = ^(cur & MAT[g]);
        end
        for (genvar g = 0; g < int'(SW); g++) begin : g_next
            assign nxt[g] = ^(cur & MAT[int'(L) + g]);
        end
    endgenerate

endmodule

// File: rtl/wscr_seed_table.sv
module wscr_seed_table
    import wscr_pkg::*;
#(
    parameter int unsigned L  = 640,
    parameter int unsigned CW = 10
) (
    input  logic [CW-1:0] cut,
    output logic [L-1:0]  seed_prbs,
    output lfsr_t         seed_state
);

    localparam int unsigned EFF_W = CW + 1;
    localparam int unsigned IDX_W = $clog2(L + 1);
    localparam logic [EFF_W-1:0] L_W = EFF_W'(L);

    // Sequence bits from the all-ones state
    function automatic logic [L-1:0] build_seq();
        lfsr_t s;
        logic [L-1:0] q;
        s = SEED_VAL;
        for (int k = 0; k < int'(L); k++) begin
            q[k] = s[SW-1];
            s = step_state(s);
        end
        return q;
    endfunction

    // State after k serial steps from the all-ones state
    function automatic logic [L:0][SW-1:0] build_states();
        logic [L:0][SW-1:0] t;
        t[0] = SEED_VAL;
        for (int k = 1; k <= int'(L); k++) begin
            t[k] = step_state(t[k-1]);
        end
        return t;
    endfunction

    localparam logic [L-1:0]       SEQ    = build_seq();
    localparam logic [L:0][SW-1:0] STATES = build_states();

    logic [EFF_W-1:0] eff;
    logic [IDX_W-1:0] idx;

    always_comb begin
        if (cut == '0 || {1'b0, cut} >= L_W) begin
            eff = L_W;
        end else begin
            eff = {1'b0, cut};
        end
        idx        = IDX_W'(L_W - eff);
        seed_prbs  = SEQ << eff;
        seed_state = STATES[idx];
    end

endmodule

// File: rtl/wscr_ctrl_fsm.sv
module wscr_ctrl_fsm
    import wscr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_seed,
    output fsm_t st,
    output sel_t sel
);

    fsm_t st_nxt;
    logic align_beat;

    assign align_beat = in_vld && in_seed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_HUNT;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_HUNT: if (align_beat) st_nxt = ST_RUN;   // ALIGN
            ST_RUN:  st_nxt = ST_RUN;                    // RESEED / ADVANCE
        endcase
    end

    always_comb begin
        sel = SEL_PASS;
        unique case (st)
            ST_HUNT: sel = align_beat ? SEL_SEED : SEL_PASS;
            ST_RUN:  sel = align_beat ? SEL_SEED : SEL_RUN;
        endcase
    end

endmodule

// File: rtl/otn_wide_scrambler.sv
module otn_wide_scrambler
    import wscr_pkg::*;
#(
    parameter int unsigned L = 640,
    localparam int unsigned CW = (L > 1) ? $clog2(L) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_seed,
    input  logic [CW-1:0] in_cut,
    input  logic [L-1:0]  in_data,
    output logic          out_vld,
    output logic [L-1:0]  out_data
);

    fsm_t         fsm_st;
    sel_t         sel;
    lfsr_t        lfsr_q;
    lfsr_t        la_nxt;
    lfsr_t        sd_state;
    logic [L-1:0] la_prbs;
    logic [L-1:0] sd_prbs;
    logic [L-1:0] mask;

    wscr_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_seed (in_seed),
        .st      (fsm_st),
        .sel     (sel)
    );

    wscr_lookahead #(.L(L)) u_la (
        .cur  (lfsr_q),
        .prbs (la_prbs),
        .nxt  (la_nxt)
    );

    wscr_seed_table #(.L(L), .CW(CW)) u_seed (
        .cut        (in_cut),
        .seed_prbs  (sd_prbs),
        .seed_state (sd_state)
    );

    always_comb begin
        mask = '0;
        unique case (sel)
            SEL_PASS: mask = '0;
            SEL_SEED: mask = sd_prbs;
            SEL_RUN:  mask = la_prbs;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED_VAL;
        end else if (in_vld) begin
            unique case (sel)
                SEL_PASS: lfsr_q <= lfsr_q;
                SEL_SEED: lfsr_q <= sd_state;
                SEL_RUN:  lfsr_q <= la_nxt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_data <= in_data ^ mask;
        end
    end

endmodule

// File: rtl/otn_wide_scrambler_chk.sv
module otn_wide_scrambler_chk
    import wscr_pkg::*;
#(
    parameter int unsigned L = 640,
    parameter int unsigned CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic          in_seed,
    input logic [CW-1:0] in_cut,
    input logic [L-1:0]  in_data,
    input logic          out_vld,
    input logic [L-1:0]  out_data,
    input fsm_t          st,
    input lfsr_t         lfsr
);

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R9
    vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(out_data));

    // R2
    hunt_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_seed && st == ST_HUNT) |=> out_data == $past(in_data));

    // R5
    full_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_seed && in_cut == '0) |=> out_data == $past(in_data));

    // R6
    first_lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_seed) |=> out_data[0] == $past(in_data[0]));

    // R4
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

endmodule

bind otn_wide_scrambler otn_wide_scrambler_chk #(.L(L), .CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_seed  (in_seed),
    .in_cut   (in_cut),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .st       (fsm_st),
    .lfsr     (lfsr_q)
);

// File: tb/otn_wide_scrambler_tb_top.sv
`timescale 1ns/1ps
module otn_wide_scrambler_tb_top;

    localparam int LW = 640;
    localparam int LN = 2;

    typedef struct packed {
        logic       v;
        logic       s;
        logic [9:0] c;
        logic [3:0] p;
        logic [3:0] r;
    } vec_t;

    // Stimulus vectors; r is the requirement the beat exercises
    localparam vec_t TBL [16] = '{
        '{1'b1, 1'b0, 10'd0,   4'd2, 4'd2},   // R2 hunt pass
        '{1'b1, 1'b0, 10'd0,   4'd3, 4'd2},   // R2 hunt pass
        '{1'b1, 1'b1, 10'd0,   4'd4, 4'd5},   // R5 full-beat alignment
        '{1'b1, 1'b0, 10'd0,   4'd0, 4'd3},   // R3 raw sequence
        '{1'b1, 1'b0, 10'd0,   4'd1, 4'd3},   // R3 ones pattern
        '{1'b0, 1'b0, 10'd0,   4'd5, 4'd8},   // R8 idle
        '{1'b1, 1'b0, 10'd0,   4'd6, 4'd8},   // R8 continues after idle
        '{1'b0, 1'b1, 10'd0,   4'd7, 4'd11},  // R11 seed without valid
        '{1'b1, 1'b0, 10'd0,   4'd0, 4'd11},  // R11 sequence not restarted
        '{1'b1, 1'b1, 10'd100, 4'd0, 4'd6},   // R6 mid-word cut
        '{1'b1, 1'b0, 10'd0,   4'd0, 4'd6},   // R6 continuation
        '{1'b1, 1'b1, 10'd1,   4'd8, 4'd6},   // R6 cut one
        '{1'b1, 1'b1, 10'd639, 4'd0, 4'd6},   // R6 cut at last lane
        '{1'b1, 1'b1, 10'd700, 4'd9, 4'd5},   // R5 cut out of range
        '{1'b1, 1'b0, 10'd0,   4'd0, 4'd7},   // R7
        '{1'b1, 1'b1, 10'd0,   4'd0, 4'd7}    // R7 back-to-back seed
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vld = 1'b0;
    logic            seed = 1'b0;
    logic [9:0]      cut_w = '0;
    logic [0:0]      cut_n = '0;
    logic [LW-1:0]   data_w = '0;
    logic            ov_w, ov_n;
    logic [LW-1:0]   od_w;
    logic [LN-1:0]   od_n;

    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    logic [15:0]     rs_w, rs_n;
    logic            run_w, run_n;
    logic [LW-1:0]   eo_w, eo_n;
    logic            ev_w, ev_n;

    always #5 clk = ~clk;

    otn_wide_scrambler #(.L(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_seed(seed),
        .in_cut(cut_w), .in_data(data_w), .out_vld(ov_w), .out_data(od_w)
    );

    otn_wide_scrambler #(.L(LN)) dut_narrow_i (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .in_seed(seed),
        .in_cut(cut_n), .in_data(data_w[LN-1:0]), .out_vld(ov_n), .out_data(od_n)
    );

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[11] ^ s[2] ^ s[0]};
    endfunction

    function automatic logic [LW-1:0] pat(input int k);
        logic [LW-1:0] r;
        if (k == 0) return '0;
        if (k == 1) return '1;
        for (int i = 0; i < LW / 32; i++) begin
            r[i*32 +: 32] = (32'(k) * 32'h9E3779B9) ^ (32'(i) * 32'h85EBCA6B) ^ 32'h3C6EF372;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Serial model of one beat for a w-lane instance
    task automatic ref_beat(input int w, input logic v, input logic s, input int c,
                            input logic [LW-1:0] d, inout logic [15:0] rs,
                            inout logic running, inout logic [LW-1:0] eo,
                            output logic ev);
        int eff;
        ev = v;
        if (!v) return;
        eo = '0;
        if (s) begin
            eff = (c == 0 || c >= w) ? w : c;
            running = 1'b1;
            rs = 16'hFFFF;
            for (int i = 0; i < w; i++) begin
                if (i < eff) eo[i] = d[i];
                else begin
                    eo[i] = d[i] ^ rs[15];
                    rs = ref_step(rs);
                end
            end
        end else if (!running) begin
            for (int i = 0; i < w; i++) eo[i] = d[i];
        end else begin
            for (int i = 0; i < w; i++) begin
                eo[i] = d[i] ^ rs[15];
                rs = ref_step(rs);
            end
        end
    endtask

    task automatic beat(input logic v, input logic s, input logic [9:0] cw,
                        input logic cn, input logic [LW-1:0] d, input string tag);
        vld = v; seed = s; cut_w = cw; cut_n = cn; data_w = d;
        ref_beat(LW, v, s, int'(cw), d, rs_w, run_w, eo_w, ev_w);
        ref_beat(LN, v, s, int'(cn), d, rs_n, run_n, eo_n, ev_n);
        @(negedge clk);
        check(ov_w === ev_w, {tag, " R9 valid"}, LW'(ov_w), LW'(ev_w));
        check(od_w === eo_w, {tag, " data"}, od_w, eo_w);
        check(ov_n === ev_n, {tag, " R10 R9 narrow valid"}, LW'(ov_n), LW'(ev_n));
        check(od_n === eo_n[LN-1:0], {tag, " R10 narrow data"}, LW'(od_n), LW'(eo_n[LN-1:0]));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0; seed = 1'b0;
        rs_w = 16'hFFFF; rs_n = 16'hFFFF;
        run_w = 1'b0; run_n = 1'b0;
        eo_w = '0; eo_n = '0;
        repeat (3) @(negedge clk);
        // R1 outputs cleared in reset
        check(ov_w === 1'b0 && ov_n === 1'b0, "R1 reset valid", LW'({ov_w, ov_n}), '0);
        check(od_w === '0, "R1 reset data", od_w, '0);
        check(od_n === '0, "R1 R10 narrow reset data", LW'(od_n), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ov_w === 1'b0 && od_w === '0, "R1 after release", od_w, '0);
    endtask

    function automatic string tag_of(input logic [3:0] r);
        case (r)
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd11: return "R11";
            default: return "R4";
        endcase
    endfunction

    initial begin
        logic [31:0] lcg;
        @(negedge clk);
        do_reset();
        foreach (TBL[k]) begin
            beat(TBL[k].v, TBL[k].s, TBL[k].c, TBL[k].c[0], pat(int'(TBL[k].p)), tag_of(TBL[k].r));
        end
        // R7 R3 R4: random frame boundaries and idle gaps
        lcg = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            beat(lcg[16] | lcg[17], lcg[23:20] == 4'd0, lcg[9:0], lcg[10],
                 pat(int'(lcg[31:24]) + 2), "R7 R3 random");
        end
        // R1 R2: reset mid-stream returns to hunting
        do_reset();
        beat(1'b1, 1'b0, 10'd0, 1'b0, pat(40), "R2 after reset");
        beat(1'b1, 1'b1, 10'd17, 1'b1, pat(0), "R6 after reset");
        beat(1'b1, 1'b0, 10'd0, 1'b0, pat(0), "R4 sequence from seed");
        beat(1'b0, 1'b0, 10'd0, 1'b0, pat(41), "R8 trailing idle");
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule